// File: doc/BRIEF.md
# Emulation Window Chip-Select and Wait-State Acknowledge Generator

This block watches the system address bus for accesses that fall in one fixed address window reserved for an emulation device. When the address strobe is seen with an address inside the window, it asserts a chip-select for that device. It then counts out a programmable number of wait states and raises an internal data-transfer acknowledge, which ends the bus cycle. When the strobe drops, the chip-select and the acknowledge both clear. The next strobe then starts a fresh cycle.

The wait value has four bits, and it comes from two registers. A 3-bit code sits in bits 6..4 of a 16-bit configuration register and gives an even wait count of twice the code. A single low-order bit, held and written on its own, adds one more. The all-ones code turns off the internal count. In that mode only the external acknowledge input can end the cycle. A combined termination output gives the bus master one signal to watch in either mode.

Top module: `csw_dtack_gen`

## Requirements
- R1: A cycle starts only when the strobe is high at a rising clock edge and the address lies within 0xFFFC0000 to 0xFFFDFFFF, both ends included. `cs_out` goes high after that edge. Addresses outside the window never assert `cs_out`.
- R2: After reset, `cfg_rdata` reads 0x0060, so the code is 110 (12 wait states). `lsb_rdata` reads 0. `cs_out`, `ack_int` and `cycle_term` are low.
- R3: The wait code is bits 6..4 of the configuration register. All other bits read as zero, and writes to them are ignored, so `cfg_rdata` always equals the last written value ANDed with 0x0070.
- R4: The low wait bit is written only through `lsb_wr` and is read back on `lsb_rdata`. A configuration-register write does not change it.
- R5: For codes 000 to 110, the total wait W is 2×code + the low bit. `ack_int` rises after the (W+1)-th rising edge that follows the edge at which `cs_out` rose.
- R6: With W = 0, `ack_int` rises at the very next edge after `cs_out` rises.
- R7: With code 111, `ack_int` stays low for the whole cycle, and the cycle is ended only by `ext_ack`.
- R8: A rising edge with the strobe low clears `cs_out` and `ack_int` after that edge and leaves the block ready for a new cycle.
- R9: The code and low bit are captured when the cycle starts. Writes during a cycle change only later cycles.
- R10: While the strobe stays high, `ack_int` stays high once it has risen, and `ack_int` is never high without `cs_out`.
- R11: `cycle_term` equals `cs_out` AND (`ack_int` OR `ext_ack`).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr | input | 1 | Configuration register write enable |
| cfg_wdata | input | 16 | Configuration register write data |
| cfg_rdata | output | 16 | Configuration register read data |
| lsb_wr | input | 1 | Low wait bit write enable |
| lsb_wdata | input | 1 | Low wait bit write data |
| lsb_rdata | output | 1 | Low wait bit read data |
| bus_addr | input | 32 | Bus address |
| bus_strobe | input | 1 | Address strobe, active high |
| ext_ack | input | 1 | External acknowledge, active high |
| cs_out | output | 1 | Emulation chip-select, active high |
| ack_int | output | 1 | Internal acknowledge, active high |
| cycle_term | output | 1 | Combined cycle termination |

## Verification
The bench uses the default parameters: a 32-bit address, the window 0xFFFC0000 to 0xFFFDFFFF, and a 3-bit code at bit 4 of a 16-bit register. With these values the longest counted wait is 13 cycles, so every code can be combined with both low-bit values inside short bus cycles. The four addresses on either side of each window edge are exercised directly. Random cycles mix in-window and out-of-window addresses, write new settings in the middle of a cycle, and toggle the external acknowledge freely. This shows that captured settings hold for the whole cycle and that code 111 never raises the internal acknowledge.

// File: rtl/csw_pkg.sv
package csw_pkg;

  // Total wait: code contributes steps of two, the separate bit adds one.
  function automatic logic [7:0] wait_total(input logic [7:0] code, input logic lsb);
    return {code[6:0], lsb};
  endfunction

  // All-ones code hands cycle termination to the external acknowledge.
  function automatic logic is_ext_code(input logic [7:0] code, input int unsigned width);
    logic [7:0] ones;
    ones = 8'((16'd1 << width) - 16'd1);
    return code == ones;
  endfunction

  // Inclusive window compare.
  function automatic logic in_range(input logic [63:0] a, input logic [63:0] lo,
                                    input logic [63:0] hi);
    return (a >= lo) && (a <= hi);
  endfunction

endpackage

// File: rtl/csw_cfg_regs.sv
module csw_cfg_regs #(
  parameter int REG_W     = 16,
  parameter int FIELD_LSB = 4,
  parameter int FIELD_W   = 3,
  parameter logic [REG_W-1:0] RST_VAL = 16'h0060
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_wr,
  input  logic [REG_W-1:0]   cfg_wdata,
  input  logic               lsb_wr,
  input  logic               lsb_wdata,
  output logic [REG_W-1:0]   cfg_rdata,
  output logic               lsb_rdata,
  output logic [FIELD_W-1:0] code_o,
  output logic               lsb_o
);
  localparam logic [FIELD_W-1:0] RST_CODE = RST_VAL[FIELD_LSB +: FIELD_W];

  logic [FIELD_W-1:0] code_q;
  logic               lsb_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      code_q <= RST_CODE;
    end else if (cfg_wr) begin
      code_q <= cfg_wdata[FIELD_LSB +: FIELD_W];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lsb_q <= 1'b0;
    end else if (lsb_wr) begin
      lsb_q <= lsb_wdata;
    end
  end

  always_comb begin
    cfg_rdata = '0;
    cfg_rdata[FIELD_LSB +: FIELD_W] = code_q;
  end

  assign lsb_rdata = lsb_q;
  assign code_o    = code_q;
  assign lsb_o     = lsb_q;
endmodule

// File: rtl/csw_window_decode.sv
module csw_window_decode #(
  parameter int ADDR_W = 32,
  parameter logic [ADDR_W-1:0] WIN_LO = 32'hFFFC_0000,
  parameter logic [ADDR_W-1:0] WIN_HI = 32'hFFFD_FFFF
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              hit
);
  import csw_pkg::*;
  assign hit = in_range(64'(addr), 64'(WIN_LO), 64'(WIN_HI));
endmodule

// File: rtl/csw_wait_timer.sv
module csw_wait_timer #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hold,
  input  logic             start,
  input  logic [CNT_W-1:0] load_val,
  input  logic             load_ext,
  output logic             active_o,
  output logic             done_o,
  output logic             ext_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             active_q;
  logic             done_q;
  logic             ext_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q    <= '0;
      active_q <= 1'b0;
      done_q   <= 1'b0;
      ext_q    <= 1'b0;
    end else if (!hold) begin
      cnt_q    <= '0;
      active_q <= 1'b0;
      done_q   <= 1'b0;
      ext_q    <= 1'b0;
    end else if (!active_q) begin
      if (start) begin
        active_q <= 1'b1;
        cnt_q    <= load_val;
        ext_q    <= load_ext;
        done_q   <= 1'b0;
      end
    end else if (!ext_q && !done_q) begin
      if (cnt_q == '0) begin
        done_q <= 1'b1;
      end else begin
        cnt_q <= cnt_q - 1'b1;
      end
    end
  end

  assign active_o = active_q;
  assign done_o   = done_q;
  assign ext_o    = ext_q;
endmodule

// File: rtl/csw_dtack_gen.sv
module csw_dtack_gen #(
  parameter int ADDR_W    = 32,
  parameter int REG_W     = 16,
  parameter int FIELD_LSB = 4,
  parameter int FIELD_W   = 3,
  parameter logic [REG_W-1:0]  RST_VAL = 16'h0060,
  parameter logic [ADDR_W-1:0] WIN_LO  = 32'hFFFC_0000,
  parameter logic [ADDR_W-1:0] WIN_HI  = 32'hFFFD_FFFF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr,
  input  logic [REG_W-1:0]  cfg_wdata,
  output logic [REG_W-1:0]  cfg_rdata,
  input  logic              lsb_wr,
  input  logic              lsb_wdata,
  output logic              lsb_rdata,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_strobe,
  input  logic              ext_ack,
  output logic              cs_out,
  output logic              ack_int,
  output logic              cycle_term
);
  import csw_pkg::*;

  localparam int MAX_WAIT = 2 * ((1 << FIELD_W) - 2) + 1;
  localparam int CNT_W    = $clog2(MAX_WAIT + 1);

  logic [FIELD_W-1:0] code_w;
  logic               lsb_w;
  logic               win_hit;
  logic               start_w;
  logic [CNT_W-1:0]   load_val_w;
  logic               load_ext_w;
  logic               ext_mode_q;

  csw_cfg_regs #(
    .REG_W(REG_W), .FIELD_LSB(FIELD_LSB), .FIELD_W(FIELD_W), .RST_VAL(RST_VAL)
  ) u_regs (
    .clk(clk), .rst_n(rst_n),
    .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
    .lsb_wr(lsb_wr), .lsb_wdata(lsb_wdata),
    .cfg_rdata(cfg_rdata), .lsb_rdata(lsb_rdata),
    .code_o(code_w), .lsb_o(lsb_w)
  );

  csw_window_decode #(
    .ADDR_W(ADDR_W), .WIN_LO(WIN_LO), .WIN_HI(WIN_HI)
  ) u_dec (
    .addr(bus_addr), .hit(win_hit)
  );

  assign start_w    = bus_strobe && win_hit;
  assign load_val_w = CNT_W'(wait_total(8'(code_w), lsb_w));
  assign load_ext_w = is_ext_code(8'(code_w), FIELD_W);

  csw_wait_timer #(
    .CNT_W(CNT_W)
  ) u_timer (
    .clk(clk), .rst_n(rst_n),
    .hold(bus_strobe), .start(start_w),
    .load_val(load_val_w), .load_ext(load_ext_w),
    .active_o(cs_out), .done_o(ack_int), .ext_o(ext_mode_q)
  );

  assign cycle_term = cs_out && (ack_int || ext_ack);
endmodule

// File: rtl/csw_dtack_chk.sv
module csw_dtack_chk #(
  parameter int REG_W     = 16,
  parameter int FIELD_LSB = 4,
  parameter int FIELD_W   = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic [REG_W-1:0] cfg_rdata,
  input logic             bus_strobe,
  input logic             win_hit,
  input logic             ext_mode,
  input logic             ext_ack,
  input logic             cs_out,
  input logic             ack_int,
  input logic             cycle_term
);
  localparam logic [REG_W-1:0] FIELD_MASK = REG_W'(((1 << FIELD_W) - 1) << FIELD_LSB);

  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_rdata & ~FIELD_MASK) == '0); // R3

  AST_START_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cs_out) |-> $past(bus_strobe && win_hit)); // R1

  AST_EXT_NO_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    ext_mode |-> !ack_int); // R7

  AST_DROP_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_strobe |=> (!cs_out && !ack_int)); // R8

  AST_ACK_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_int && bus_strobe) |=> ack_int); // R10

  AST_ACK_WITH_CS: assert property (@(posedge clk) disable iff (!rst_n)
    ack_int |-> cs_out); // R10

  AST_TERM_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    cycle_term == (cs_out && (ack_int || ext_ack))); // R11
endmodule

bind csw_dtack_gen csw_dtack_chk #(
  .REG_W(REG_W), .FIELD_LSB(FIELD_LSB), .FIELD_W(FIELD_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_rdata(cfg_rdata),
  .bus_strobe(bus_strobe), .win_hit(win_hit), .ext_mode(ext_mode_q),
  .ext_ack(ext_ack), .cs_out(cs_out), .ack_int(ack_int), .cycle_term(cycle_term)
);

// File: tb/test_csw_dtack_gen.sv
module test_csw_dtack_gen;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_wr = 1'b0;
  logic [15:0] cfg_wdata = '0;
  logic [15:0] cfg_rdata;
  logic        lsb_wr = 1'b0;
  logic        lsb_wdata = 1'b0;
  logic        lsb_rdata;
  logic [31:0] bus_addr = '0;
  logic        bus_strobe = 1'b0;
  logic        ext_ack = 1'b0;
  logic        cs_out;
  logic        ack_int;
  logic        cycle_term;

  int vectors = 0;
  int fails = 0;
  bit finished = 1'b0;
  logic [2:0] m_code = 3'b110;
  logic       m_lsb = 1'b0;

  always #2 clk = ~clk;

  csw_dtack_gen i_csw_dtack_gen (
    .clk(clk), .rst_n(rst_n),
    .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .lsb_wr(lsb_wr), .lsb_wdata(lsb_wdata), .lsb_rdata(lsb_rdata),
    .bus_addr(bus_addr), .bus_strobe(bus_strobe), .ext_ack(ext_ack),
    .cs_out(cs_out), .ack_int(ack_int), .cycle_term(cycle_term)
  );

  function automatic bit exp_in_window(input logic [31:0] a);
    return a[31:17] == 15'h7FFE;
  endfunction

  function automatic int exp_wait(input logic [2:0] c, input logic l);
    return 2 * int'(c) + int'(l);
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic write_cfg(input logic [15:0] d);
    logic l_before;
    l_before = lsb_rdata;
    @(negedge clk); cfg_wr = 1'b1; cfg_wdata = d;
    @(negedge clk); cfg_wr = 1'b0; #1;
    m_code = d[6:4];
    check("R3", 32'(cfg_rdata), 32'(d & 16'h0070));
    check("R4", 32'(lsb_rdata), 32'(l_before));
  endtask

  task automatic write_lsb(input logic l);
    @(negedge clk); lsb_wr = 1'b1; lsb_wdata = l;
    @(negedge clk); lsb_wr = 1'b0; #1;
    m_lsb = l;
    check("R4", 32'(lsb_rdata), 32'(l));
  endtask

  task automatic bus_cycle(input logic [31:0] a, input int extra, input bit midwrite);
    bit in_w, ext;
    int w, hold;
    logic [15:0] nd;
    logic nl;
    in_w = exp_in_window(a);
    ext  = (m_code == 3'b111);
    w    = exp_wait(m_code, m_lsb);
    hold = ext ? 6 + extra : w + 3 + extra;
    nd = 16'($urandom); nl = 1'($urandom);
    @(negedge clk); bus_addr = a; bus_strobe = 1'b1;
    for (int k = 1; k <= hold; k++) begin
      @(negedge clk);
      ext_ack = 1'($urandom);
      if (midwrite && k == 1) begin
        cfg_wr = 1'b1; cfg_wdata = nd; lsb_wr = 1'b1; lsb_wdata = nl;
      end else begin
        cfg_wr = 1'b0; lsb_wr = 1'b0;
      end
      #1;
      check(in_w ? "R1 R5" : "R1 outside", 32'(cs_out), 32'(in_w));
      if (w == 0 && !ext)
        check("R6", 32'(ack_int), 32'(in_w && k >= 2));
      else if (ext)
        check("R7", 32'(ack_int), 32'd0);
      else
        check(midwrite ? "R9" : "R5 R10", 32'(ack_int), 32'(in_w && k >= w + 2));
      check("R11 R7", 32'(cycle_term), 32'(in_w && ((!ext && k >= w + 2) || ext_ack)));
    end
    if (midwrite) begin m_code = nd[6:4]; m_lsb = nl; end
    @(negedge clk); bus_strobe = 1'b0; ext_ack = 1'b0; cfg_wr = 1'b0; lsb_wr = 1'b0;
    @(negedge clk); #1;
    check("R8 cs", 32'(cs_out), 32'd0);
    check("R8 ack", 32'(ack_int), 32'd0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog actual=running expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    check("R2 cfg", 32'(cfg_rdata), 32'h0060);
    check("R2 lsb", 32'(lsb_rdata), 32'd0);
    check("R2 cs", 32'(cs_out), 32'd0);
    check("R2 ack", 32'(ack_int), 32'd0);
    check("R2 term", 32'(cycle_term), 32'd0);
    // R2: default twelve waits
    bus_cycle(32'hFFFC_1234, 1, 1'b0);
    write_cfg(16'hFFFF);
    write_cfg(16'hFF8F);
    write_lsb(1'b1);
    write_cfg(16'h0000);
    // R6: zero wait
    write_lsb(1'b0);
    bus_cycle(32'hFFFD_0000, 2, 1'b0);
    // R1 boundaries
    write_cfg(16'h0020);
    bus_cycle(32'hFFFB_FFFF, 0, 1'b0);
    bus_cycle(32'hFFFC_0000, 0, 1'b0);
    bus_cycle(32'hFFFD_FFFF, 0, 1'b0);
    bus_cycle(32'hFFFE_0000, 0, 1'b0);
    // R5: every code with both low bits
    for (int c = 0; c < 8; c++) begin
      for (int l = 0; l < 2; l++) begin
        write_cfg(16'(c << 4));
        write_lsb(1'(l));
        bus_cycle(32'hFFFC_8000, 1, 1'b0);
      end
    end
    // R9 directed: long wait captured, write shortens later cycles only
    write_cfg(16'h0060); write_lsb(1'b1);
    bus_cycle(32'hFFFC_0040, 0, 1'b1);
    for (int i = 0; i < 300; i++) begin
      logic [31:0] a;
      a = ($urandom_range(0, 3) != 0) ? 32'hFFFC_0000 + ($urandom & 32'h1FFFF) : $urandom;
      if ($urandom_range(0, 5) == 0) write_cfg(16'($urandom));
      if ($urandom_range(0, 5) == 0) write_lsb(1'($urandom));
      bus_cycle(a, $urandom_range(0, 3), $urandom_range(0, 3) == 0);
    end
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule